// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits on the byte-wide receive path of an Ethernet MAC, between the frame decoder and the client. Each frame arrives as bytes marked with start, end and valid. The block decides once per frame whether the frame goes to the client or is discarded. The decision uses the destination address, the EtherType, the control opcode and a configuration word. Bytes are held in a small buffer until enough of the header has arrived to classify the frame. After that, the held bytes are either committed to the client side or discarded as a group.

A unicast destination is matched against one primary address and up to four supplementary addresses, each of which can be switched on or off. Multicast and broadcast destinations follow a single policy bit. MAC control frames and pause frames each have their own forward or drop bit, and those bits override address filtering. A global receive-off bit discards whole frames, and it is sampled only when a frame starts. A busy flag reports that a transfer is under way. A one-cycle pause request pulse reports a pause frame that should be processed further.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset the configuration word equals 0x3 (all unicast and all multicast accepted) and the receive-off bit is 0, `outValid`, `busy` and `pauseReq` are 0, and frames are accepted without any configuration write.
- R2: While the receive-off bit (`cfgRxOff`, loaded by `cfgWr`) is 1, every frame that starts is discarded; while it is 0, frames are filtered normally.
- R3: A change of the receive-off bit during a frame does not affect that frame; it applies from the next start-of-frame.
- R4: Frame bytes 0..5 form the destination, with byte 0 in bits 47:40. A destination whose byte 0 has bit 0 clear is unicast. With configuration bit 0 clear, a unicast frame is kept only if its destination equals `primaryAddr` or an enabled supplementary address.
- R5: Supplementary address k (`suppAddr[48k+47:48k]`) takes part in matching only while configuration bit 16+k is 1.
- R6: With configuration bit 0 set, every unicast frame is kept.
- R7: A destination whose byte 0 has bit 0 set, broadcast included, is multicast. Such a frame is kept exactly when configuration bit 1 is 1.
- R8: A frame whose bytes 12..13 are 0x8808 and which is not a pause frame is a control frame. It is kept exactly when configuration bit 3 is 1, whatever its destination.
- R9: A pause frame is a control frame with destination 01-80-C2-00-00-01 and bytes 14..15 equal to 0x0001. It is kept exactly when configuration bit 4 is 1. One cycle after its 16th byte, `pauseReq` pulses for one cycle, unless configuration bit 5 is 1.
- R10: A frame shorter than 14 bytes is discarded. A frame of 14 or 15 bytes cannot be a pause frame.
- R11: A kept frame is delivered unchanged and in order, with `outSop` on its first byte and `outEop` on its last. A discarded frame produces no output byte. Back-to-back frames are each handled on their own.
- R12: `busy` is 1 from the cycle after a multi-byte frame starts until its last kept byte has left, and it is 0 when no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Load strobe for the configuration word and the receive-off bit |
| cfgRxOff | input | 1 | Receive-off value; 1 discards frames |
| cfgCtl | input | 32 | Configuration word: bit0 all unicast, bit1 all multicast, bit3 forward control, bit4 forward pause, bit5 ignore pause, bits16..19 supplementary enables |
| primaryAddr | input | 48 | Primary station address, first wire octet in bits 47:40 |
| suppAddr | input | 192 | Four supplementary addresses, entry k in bits 48k+47:48k |
| inData | input | 8 | Received byte |
| inValid | input | 1 | Byte qualifier |
| inSop | input | 1 | First byte of a frame |
| inEop | input | 1 | Last byte of a frame |
| outData | output | 8 | Delivered byte |
| outValid | output | 1 | Delivered byte qualifier |
| outSop | output | 1 | First delivered byte of a frame |
| outEop | output | 1 | Last delivered byte of a frame |
| busy | output | 1 | A receive transfer is in progress |
| pauseReq | output | 1 | One-cycle pulse for a pause frame to be processed |

## Verification
The filter is driven with unicast frames to the primary address, to each supplementary address with its enable on and off, and to a foreign address. This separates address matching from the accept-all bit. Multicast and broadcast frames are sent under each multicast policy. Control and pause frames are addressed so that the address policy would give the opposite answer, which shows that the type policy takes precedence. Frames of 1, 13, 14, 15 and 16 bytes probe the header-length limits. Back-to-back frames and receive-off writes in the middle of a frame separate per-frame decisions from boundary handling.

// File: rtl/rx_filter_pkg.sv
`timescale 1ns/1ps
package rx_filter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_PASS,
    ST_DROP
  } fltState_e;

  // strobes from the control to the buffer
  typedef struct packed {
    logic wrEn;
    logic wrSop;
    logic wrEop;
    logic commit;
    logic rollback;
  } bufCmd_t;

  localparam logic [15:0] CTRL_ETYPE = 16'h8808;
  localparam logic [47:0] PAUSE_DST  = 48'h0180C2000001;
  localparam logic [15:0] PAUSE_OPC  = 16'h0001;

  localparam int BIT_ALL_UNI   = 0;
  localparam int BIT_ALL_MULTI = 1;
  localparam int BIT_FWD_CTRL  = 3;
  localparam int BIT_FWD_PAUSE = 4;
  localparam int BIT_IGN_PAUSE = 5;
  localparam int BIT_SUPP_BASE = 16;

  localparam logic [31:0] CTL_RESET = 32'h0000_0003;

endpackage

// File: rtl/rx_filter_match.sv
`timescale 1ns/1ps
module rx_filter_match #(
  parameter int ADDR_W   = 48,
  parameter int NUM_SUPP = 4
) (
  input  logic [ADDR_W-1:0]          dstAddr,
  input  logic [ADDR_W-1:0]          primaryAddr,
  input  logic [NUM_SUPP*ADDR_W-1:0] suppAddr,
  input  logic [NUM_SUPP-1:0]        suppEn,
  output logic                       hit
);

  logic [NUM_SUPP-1:0] suppHit;

  for (genvar k = 0; k < NUM_SUPP; k++) begin : gSupp
    assign suppHit[k] = suppEn[k] && (suppAddr[k*ADDR_W +: ADDR_W] == dstAddr);
  end

  assign hit = (dstAddr == primaryAddr) || (|suppHit);

endmodule

// File: rtl/rx_filter_ctrl.sv
`timescale 1ns/1ps
module rx_filter_ctrl
  import rx_filter_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int NUM_SUPP = 4,
  parameter int HDR_LEN  = 14,
  parameter int HOLD_LEN = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWr,
  input  logic                       cfgRxOff,
  input  logic [31:0]                cfgCtl,
  input  logic [ADDR_W-1:0]          primaryAddr,
  input  logic [NUM_SUPP*ADDR_W-1:0] suppAddr,
  input  logic [7:0]                 inData,
  input  logic                       inValid,
  input  logic                       inSop,
  input  logic                       inEop,
  output bufCmd_t                    cmd,
  output logic                       frameActive,
  output logic                       pauseReq
);

  localparam int CNT_W  = $clog2(HOLD_LEN + 1);
  localparam int MC_BIT = ADDR_W - 8;
  localparam int OCT_N  = ADDR_W / 8;

  fltState_e state, stNext;
  logic [CNT_W-1:0] cnt, cntNext, idx, lenNow;
  logic [31:0] ctlReg;
  logic offReg;

  logic [7:0] hdrReg  [HOLD_LEN];
  logic [7:0] hdrView [HOLD_LEN];

  logic holdAct, decide, keepFrame, addrHit;
  logic hdrOk, opcOk, isCtrl, isPause, isMulti;
  logic [ADDR_W-1:0] dstAddr;
  logic [15:0] etype, opcode;

  logic unusedBits;
  assign unusedBits = ^{ctlReg[31:BIT_SUPP_BASE+NUM_SUPP], ctlReg[BIT_SUPP_BASE-1:BIT_IGN_PAUSE+1],
                        ctlReg[2], hdrView[6], hdrView[7], hdrView[8], hdrView[9],
                        hdrView[10], hdrView[11]};

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= CTL_RESET;
      offReg <= 1'b0;
    end else if (cfgWr) begin
      ctlReg <= cfgCtl;
      offReg <= cfgRxOff;
    end
  end

  // receive-off is looked at only on a start byte seen in idle
  assign holdAct = inValid && ((state == ST_HOLD) ||
                               (state == ST_IDLE && inSop && !offReg));
  assign idx     = (state == ST_IDLE) ? '0 : cnt;
  assign lenNow  = idx + CNT_W'(1);
  assign decide  = holdAct && (inEop || (idx == CNT_W'(HOLD_LEN - 1)));

  // header capture; view includes the byte arriving now
  for (genvar i = 0; i < HOLD_LEN; i++) begin : gHdr
    assign hdrView[i] = (holdAct && idx == CNT_W'(i)) ? inData : hdrReg[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              hdrReg[i] <= '0;
      else if (holdAct && idx == CNT_W'(i))   hdrReg[i] <= inData;
    end
  end

  for (genvar o = 0; o < OCT_N; o++) begin : gDst
    assign dstAddr[ADDR_W-1-8*o -: 8] = hdrView[o];
  end

  assign etype  = {hdrView[HDR_LEN-2], hdrView[HDR_LEN-1]};
  assign opcode = {hdrView[HDR_LEN],   hdrView[HDR_LEN+1]};

  assign hdrOk   = lenNow >= CNT_W'(HDR_LEN);
  assign opcOk   = lenNow >= CNT_W'(HDR_LEN + 2);
  assign isCtrl  = hdrOk && (etype == CTRL_ETYPE);
  assign isPause = isCtrl && opcOk && (dstAddr == PAUSE_DST) && (opcode == PAUSE_OPC);
  assign isMulti = dstAddr[MC_BIT];

  rx_filter_match #(
    .ADDR_W   (ADDR_W),
    .NUM_SUPP (NUM_SUPP)
  ) uMatch (
    .dstAddr     (dstAddr),
    .primaryAddr (primaryAddr),
    .suppAddr    (suppAddr),
    .suppEn      (ctlReg[BIT_SUPP_BASE +: NUM_SUPP]),
    .hit         (addrHit)
  );

  // type policy ranks above address policy
  always_comb begin
    if (!hdrOk)        keepFrame = 1'b0;
    else if (isPause)  keepFrame = ctlReg[BIT_FWD_PAUSE];
    else if (isCtrl)   keepFrame = ctlReg[BIT_FWD_CTRL];
    else if (isMulti)  keepFrame = ctlReg[BIT_ALL_MULTI];
    else               keepFrame = ctlReg[BIT_ALL_UNI] || addrHit;
  end

  always_comb begin
    cmd     = '0;
    stNext  = state;
    cntNext = cnt;
    unique case (state)
      ST_IDLE: if (inValid && inSop && offReg) stNext = inEop ? ST_IDLE : ST_DROP;
      ST_HOLD: ;
      ST_PASS: if (inValid) begin
        cmd.wrEn   = 1'b1;
        cmd.wrEop  = inEop;
        cmd.commit = 1'b1;
        if (inEop) stNext = ST_IDLE;
      end
      ST_DROP: if (inValid && inEop) stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
    if (holdAct) begin
      cmd.wrEn  = 1'b1;
      cmd.wrSop = (state == ST_IDLE);
      cmd.wrEop = inEop;
      if (decide) begin
        cntNext = '0;
        if (keepFrame) begin
          cmd.commit = 1'b1;
          stNext     = inEop ? ST_IDLE : ST_PASS;
        end else begin
          cmd.rollback = 1'b1;
          stNext       = inEop ? ST_IDLE : ST_DROP;
        end
      end else begin
        cntNext = lenNow;
        stNext  = ST_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pauseReq <= 1'b0;
    end else begin
      state    <= stNext;
      cnt      <= cntNext;
      pauseReq <= decide && isPause && !ctlReg[BIT_IGN_PAUSE];
    end
  end

  assign frameActive = (state != ST_IDLE);

endmodule

// File: rtl/rx_filter_buf.sv
`timescale 1ns/1ps
module rx_filter_buf
  import rx_filter_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  bufCmd_t    cmd,
  input  logic [7:0] inData,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       outSop,
  output logic       outEop,
  output logic       bufEmpty
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [9:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, cmPtr, rdPtr;
  logic          avail;

  assign avail    = (rdPtr != cmPtr);
  assign bufEmpty = (rdPtr == wrPtr);

  always_ff @(posedge clk) begin
    if (cmd.wrEn && !cmd.rollback) mem[wrPtr[AW-1:0]] <= {cmd.wrEop, cmd.wrSop, inData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      cmPtr    <= '0;
      rdPtr    <= '0;
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outData  <= '0;
    end else begin
      // uncommitted bytes are thrown back by rewinding the write pointer
      if (cmd.rollback)  wrPtr <= cmPtr;
      else if (cmd.wrEn) wrPtr <= wrPtr + PW'(1);
      if (cmd.commit)    cmPtr <= wrPtr + PW'(cmd.wrEn);
      if (avail) begin
        {outEop, outSop, outData} <= mem[rdPtr[AW-1:0]];
        outValid <= 1'b1;
        rdPtr    <= rdPtr + PW'(1);
      end else begin
        outValid <= 1'b0;
        outSop   <= 1'b0;
        outEop   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rx_accept_filter.sv
`timescale 1ns/1ps
module rx_accept_filter
  import rx_filter_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int NUM_SUPP = 4,
  parameter int HDR_LEN  = 14,
  parameter int HOLD_LEN = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWr,
  input  logic                       cfgRxOff,
  input  logic [31:0]                cfgCtl,
  input  logic [ADDR_W-1:0]          primaryAddr,
  input  logic [NUM_SUPP*ADDR_W-1:0] suppAddr,
  input  logic [7:0]                 inData,
  input  logic                       inValid,
  input  logic                       inSop,
  input  logic                       inEop,
  output logic [7:0]                 outData,
  output logic                       outValid,
  output logic                       outSop,
  output logic                       outEop,
  output logic                       busy,
  output logic                       pauseReq
);

  localparam int BUF_DEPTH = 2 * HOLD_LEN;

  bufCmd_t cmd;
  logic    frameActive, bufEmpty;

  rx_filter_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_SUPP (NUM_SUPP),
    .HDR_LEN  (HDR_LEN),
    .HOLD_LEN (HOLD_LEN)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWr       (cfgWr),
    .cfgRxOff    (cfgRxOff),
    .cfgCtl      (cfgCtl),
    .primaryAddr (primaryAddr),
    .suppAddr    (suppAddr),
    .inData      (inData),
    .inValid     (inValid),
    .inSop       (inSop),
    .inEop       (inEop),
    .cmd         (cmd),
    .frameActive (frameActive),
    .pauseReq    (pauseReq)
  );

  rx_filter_buf #(
    .DEPTH (BUF_DEPTH)
  ) uBuf (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .inData   (inData),
    .outData  (outData),
    .outValid (outValid),
    .outSop   (outSop),
    .outEop   (outEop),
    .bufEmpty (bufEmpty)
  );

  assign busy = frameActive || !bufEmpty || outValid;

endmodule

// File: rtl/rx_accept_filter_chk.sv
`timescale 1ns/1ps
module rx_accept_filter_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inSop,
  input logic inEop,
  input logic outValid,
  input logic outSop,
  input logic outEop,
  input logic busy,
  input logic pauseReq
);

  logic outFrm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   outFrm <= 1'b0;
    else if (outValid && outEop) outFrm <= 1'b0;
    else if (outValid && outSop) outFrm <= 1'b1;
  end

  assert_sop_opens_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outSop |-> !outFrm);

  assert_body_inside_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outSop |-> outFrm);

  assert_busy_on_start_R12: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inSop && !inEop |=> busy);

  assert_pause_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    pauseReq |=> !pauseReq);

  assert_pause_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    pauseReq |-> $past(inValid));

endmodule

bind rx_accept_filter rx_accept_filter_chk chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inSop    (inSop),
  .inEop    (inEop),
  .outValid (outValid),
  .outSop   (outSop),
  .outEop   (outEop),
  .busy     (busy),
  .pauseReq (pauseReq)
);

// File: tb/tb_rx_accept_filter.sv
`timescale 1ns/1ps
module tb_rx_accept_filter;

  localparam int CLK_PERIOD = 10;

  localparam logic [47:0] PRI = 48'h021122334455;
  localparam logic [47:0] OTH = 48'h02DEADBEEF01;
  localparam logic [47:0] SB  = 48'h02AABBCCDDE0;
  localparam logic [47:0] MC  = 48'h01005E000001;
  localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] PD  = 48'h0180C2000001;

  typedef struct packed {
    logic [31:0] ctl;
    logic [47:0] dst;
    logic [15:0] etype;
    logic [15:0] opc;
    logic [7:0]  len;
    logic        keep;
    logic        pause;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{32'h3,     PRI,    16'h0800, 16'h0, 8'd60, 1'b1, 1'b0, 8'd6},  // R6
    '{32'h0,     PRI,    16'h0800, 16'h0, 8'd40, 1'b1, 1'b0, 8'd4},  // R4
    '{32'h0,     OTH,    16'h0800, 16'h0, 8'd40, 1'b0, 1'b0, 8'd4},  // R4
    '{32'h0,     SB + 1, 16'h0800, 16'h0, 8'd40, 1'b0, 1'b0, 8'd5},  // R5
    '{32'h20000, SB + 1, 16'h0800, 16'h0, 8'd40, 1'b1, 1'b0, 8'd5},  // R5
    '{32'h20000, SB + 2, 16'h0800, 16'h0, 8'd40, 1'b0, 1'b0, 8'd5},  // R5
    '{32'hF0000, SB + 3, 16'h0800, 16'h0, 8'd40, 1'b1, 1'b0, 8'd5},  // R5
    '{32'h1,     OTH,    16'h0800, 16'h0, 8'd40, 1'b1, 1'b0, 8'd6},  // R6
    '{32'h1,     MC,     16'h0800, 16'h0, 8'd40, 1'b0, 1'b0, 8'd7},  // R7
    '{32'h2,     MC,     16'h0800, 16'h0, 8'd40, 1'b1, 1'b0, 8'd7},  // R7
    '{32'h2,     BC,     16'h0800, 16'h0, 8'd40, 1'b1, 1'b0, 8'd7},  // R7
    '{32'h1,     BC,     16'h0800, 16'h0, 8'd40, 1'b0, 1'b0, 8'd7},  // R7
    '{32'h3,     OTH,    16'h8808, 16'h2, 8'd60, 1'b0, 1'b0, 8'd8},  // R8
    '{32'h8,     OTH,    16'h8808, 16'h2, 8'd60, 1'b1, 1'b0, 8'd8},  // R8
    '{32'h3,     PD,     16'h8808, 16'h1, 8'd60, 1'b0, 1'b1, 8'd9},  // R9
    '{32'h10,    PD,     16'h8808, 16'h1, 8'd60, 1'b1, 1'b1, 8'd9},  // R9
    '{32'h30,    PD,     16'h8808, 16'h1, 8'd60, 1'b1, 1'b0, 8'd9},  // R9
    '{32'h8,     PD,     16'h8808, 16'h1, 8'd60, 1'b0, 1'b1, 8'd9},  // R9
    '{32'h3,     PRI,    16'h0800, 16'h0, 8'd13, 1'b0, 1'b0, 8'd10}, // R10
    '{32'h3,     PRI,    16'h0800, 16'h0, 8'd14, 1'b1, 1'b0, 8'd10}, // R10
    '{32'h8,     PD,     16'h8808, 16'h1, 8'd15, 1'b1, 1'b0, 8'd10}, // R10
    '{32'h3,     PRI,    16'h0800, 16'h0, 8'd16, 1'b1, 1'b0, 8'd11}  // R11
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWr = 1'b0;
  logic         cfgRxOff = 1'b0;
  logic [31:0]  cfgCtl = 32'h3;
  logic [47:0]  primaryAddr = PRI;
  logic [191:0] suppAddr = {SB + 3, SB + 2, SB + 1, SB};
  logic [7:0]   inData = '0;
  logic         inValid = 1'b0;
  logic         inSop = 1'b0;
  logic         inEop = 1'b0;
  logic [7:0]   outData;
  logic         outValid, outSop, outEop, busy, pauseReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] rxBuf [256];
  int rxCnt = 0, sopCnt = 0, eopCnt = 0, lastEopAt = -1;
  bit pauseSeen = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_accept_filter dut (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWr       (cfgWr),
    .cfgRxOff    (cfgRxOff),
    .cfgCtl      (cfgCtl),
    .primaryAddr (primaryAddr),
    .suppAddr    (suppAddr),
    .inData      (inData),
    .inValid     (inValid),
    .inSop       (inSop),
    .inEop       (inEop),
    .outData     (outData),
    .outValid    (outValid),
    .outSop      (outSop),
    .outEop      (outEop),
    .busy        (busy),
    .pauseReq    (pauseReq)
  );

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (rxCnt < 256) rxBuf[rxCnt] = outData;
      if (outSop) sopCnt++;
      if (outEop) begin
        eopCnt++;
        lastEopAt = rxCnt;
      end
      rxCnt++;
    end
    if (rstN && pauseReq) pauseSeen = 1'b1;
  end

  function automatic logic [7:0] genByte(int i, logic [47:0] dst, logic [15:0] et, logic [15:0] op);
    if (i < 6)       return dst[47 - 8*i -: 8];
    else if (i == 12) return et[15:8];
    else if (i == 13) return et[7:0];
    else if (i == 14) return op[15:8];
    else if (i == 15) return op[7:0];
    else              return 8'(i * 13 + 5);
  endfunction

  task automatic check(bit ok, int req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    rxCnt = 0; sopCnt = 0; eopCnt = 0; lastEopAt = -1; pauseSeen = 1'b0;
  endtask

  task automatic cfgWrite(logic [31:0] ctl, logic off);
    @(negedge clk);
    cfgWr = 1'b1; cfgCtl = ctl; cfgRxOff = off;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic sendFrame(logic [47:0] dst, logic [15:0] et, logic [15:0] op, int len,
                           int midAt, logic midOff, bit tail);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inSop   = (i == 0);
      inEop   = (i == len - 1);
      inData  = genByte(i, dst, et, op);
      cfgWr   = (i == midAt);
      if (i == midAt) cfgRxOff = midOff;
    end
    if (tail) begin
      @(negedge clk);
      inValid = 1'b0; inSop = 1'b0; inEop = 1'b0; cfgWr = 1'b0;
    end
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  task automatic checkFrame(int req, logic [47:0] dst, logic [15:0] et, logic [15:0] op,
                            int len, bit keep);
    bit ok;
    int expCnt;
    expCnt = keep ? len : 0;
    ok = (rxCnt == expCnt);
    if (keep) begin
      ok = ok && (sopCnt == 1) && (eopCnt == 1) && (lastEopAt == len - 1);
      for (int i = 0; i < len && i < 256; i++)
        if (rxBuf[i] !== genByte(i, dst, et, op)) ok = 1'b0;
    end else begin
      ok = ok && (sopCnt == 0);
    end
    check(ok, req, "delivered bytes", rxCnt, expCnt);
  endtask

  initial begin
    // reset state, R1
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, 1, "outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, 1, "busy after reset", int'(busy), 0);
    check(pauseReq == 1'b0, 1, "pauseReq after reset", int'(pauseReq), 0);

    // R1: default word accepts all unicast and multicast
    clearMon();
    sendFrame(OTH, 16'h0800, 16'h0, 40, -1, 1'b0, 1'b1);
    drain();
    checkFrame(1, OTH, 16'h0800, 16'h0, 40, 1'b1);
    clearMon();
    sendFrame(MC, 16'h0800, 16'h0, 40, -1, 1'b0, 1'b1);
    drain();
    checkFrame(1, MC, 16'h0800, 16'h0, 40, 1'b1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      cfgWrite(VECS[v].ctl, 1'b0);
      clearMon();
      sendFrame(VECS[v].dst, VECS[v].etype, VECS[v].opc, int'(VECS[v].len), -1, 1'b0, 1'b1);
      drain();
      checkFrame(int'(VECS[v].req), VECS[v].dst, VECS[v].etype, VECS[v].opc,
                 int'(VECS[v].len), VECS[v].keep);
      check(pauseSeen == VECS[v].pause, 9, "pause pulse", int'(pauseSeen), int'(VECS[v].pause));
    end

    // R2: receive-off discards, clearing it restores
    cfgWrite(32'h3, 1'b1);
    clearMon();
    sendFrame(PRI, 16'h0800, 16'h0, 50, -1, 1'b0, 1'b1);
    drain();
    checkFrame(2, PRI, 16'h0800, 16'h0, 50, 1'b0);
    cfgWrite(32'h3, 1'b0);
    clearMon();
    sendFrame(PRI, 16'h0800, 16'h0, 50, -1, 1'b0, 1'b1);
    drain();
    checkFrame(2, PRI, 16'h0800, 16'h0, 50, 1'b1);

    // R3: mid-frame change waits for the next frame
    clearMon();
    sendFrame(PRI, 16'h0800, 16'h0, 60, 20, 1'b1, 1'b1);
    drain();
    checkFrame(3, PRI, 16'h0800, 16'h0, 60, 1'b1);
    clearMon();
    sendFrame(PRI, 16'h0800, 16'h0, 60, -1, 1'b0, 1'b1);
    drain();
    checkFrame(3, PRI, 16'h0800, 16'h0, 60, 1'b0);
    clearMon();
    sendFrame(PRI, 16'h0800, 16'h0, 60, 20, 1'b0, 1'b1);
    drain();
    checkFrame(3, PRI, 16'h0800, 16'h0, 60, 1'b0);
    clearMon();
    sendFrame(PRI, 16'h0800, 16'h0, 60, -1, 1'b0, 1'b1);
    drain();
    checkFrame(3, PRI, 16'h0800, 16'h0, 60, 1'b1);

    // R11: back-to-back frames, first kept, second kept
    clearMon();
    sendFrame(PRI, 16'h0800, 16'h0, 40, -1, 1'b0, 1'b0);
    sendFrame(OTH, 16'h0800, 16'h0, 50, -1, 1'b0, 1'b1);
    drain();
    check(rxCnt == 90 && sopCnt == 2 && eopCnt == 2, 11, "back-to-back bytes", rxCnt, 90);

    // R11: kept frame then dropped frame without a gap
    cfgWrite(32'h0, 1'b0);
    clearMon();
    sendFrame(PRI, 16'h0800, 16'h0, 30, -1, 1'b0, 1'b0);
    sendFrame(OTH, 16'h0800, 16'h0, 30, -1, 1'b0, 1'b1);
    drain();
    check(rxCnt == 30 && sopCnt == 1 && eopCnt == 1, 11, "keep-then-drop bytes", rxCnt, 30);
    cfgWrite(32'h3, 1'b0);

    // R10: single-byte frame
    clearMon();
    sendFrame(PRI, 16'h0800, 16'h0, 1, -1, 1'b0, 1'b1);
    drain();
    checkFrame(10, PRI, 16'h0800, 16'h0, 1, 1'b0);

    // R12: busy during and after a transfer
    clearMon();
    fork
      sendFrame(PRI, 16'h0800, 16'h0, 40, -1, 1'b0, 1'b1);
      begin
        repeat (5) @(negedge clk);
        #1 check(busy == 1'b1, 12, "busy mid-frame", int'(busy), 1);
      end
    join
    drain();
    check(busy == 1'b0, 12, "busy when idle", int'(busy), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule